// File: doc/BRIEF.md
# Dual-Column Stream Interleaver

This block sits on a front-end hybrid next to two columns of readout chips. Each column returns its hit data as one serial bit stream, handed down the column by token passing. The block combines the two streams onto a single output line. The output line runs at twice the readout clock, and the bits of the two columns alternate on it. The block also produces the readout clock for the chips, in a fast mode or a slow mode. The fast mode is twice the crossing clock and the slow mode equals it.

The block also serves the crossing-rate control lines. One input line carries both triggers and resets, and the block tells them apart by how long the line stays high. A second serial line carries addressed command frames. A frame is forwarded to the chips only when its address equals the unit's static address pins, or when it carries the broadcast address.

The design runs on a single supplied clock, `clk`, at four times the crossing rate. Every slower rate is built from a two-bit phase counter. The crossing-clock sample point is phase 0. In fast mode a readout cycle lasts 2 `clk` cycles and each output bit slot lasts 1. In slow mode a readout cycle lasts 4 `clk` cycles and each bit slot lasts 2.

Top module: `dual_col_interleaver`

## Requirements
- R1: While `rst` is high at a clock edge, the phase counter returns to 0, and after that edge `ser_out`, `rd_clk`, `trig_out`, `chip_rst` and `cmd_stb` are all 0.
- R2: Count edges from the first edge with `rst` low, starting at n=0. In fast mode (`fast_mode`=1), `rd_clk` after edge n is 1 when n is even. In slow mode, `rd_clk` after edge n is 1 when n mod 4 is 0 or 1.
- R3: A readout cycle starts at edge n when n is even (fast mode) or when n mod 4 is 0 (slow mode). At that start edge the block samples `col_a` and `col_b`, and `ser_out` shows the sampled `col_a`.
- R4: The second half of a readout cycle begins one edge after the start in fast mode, and two edges after it in slow mode. From that edge `ser_out` shows the `col_b` value sampled at the start. `ser_out` changes at no other edge.
- R5: Split the output by slot. The first-half bits, taken in order, equal the sampled column A stream, and the second-half bits equal the sampled column B stream, in both modes.
- R6: `trig_line` is sampled only at edges where n mod 4 is 0 (crossing samples). Suppose it is high at exactly one crossing sample and low at the next. Then `trig_out` is 1 for the 4 clock cycles after that low sample, and is 0 otherwise.
- R7: A high run on `trig_line` of exactly two crossing samples produces neither `trig_out` nor `chip_rst`.
- R8: A high run of three or more crossing samples sets `chip_rst` to 1 after the third high sample. `chip_rst` stays 1 until the first low sample. `trig_out` and `chip_rst` are never 1 together.
- R9: `cmd_line` is read at crossing samples. A command frame is a 1 start bit, then ADDR_W address bits MSB first, then CMD_W code bits MSB first. When the address equals `unit_addr`, `cmd_stb` is 1 for one clock and `cmd_code` holds the code.
- R10: A frame whose address is neither `unit_addr` nor all ones gives no `cmd_stb`. A frame with the all-ones address is accepted whatever `unit_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supplied clock at four times the crossing rate |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1: readout clock at twice the crossing rate; 0: at the crossing rate |
| unit_addr | input | ADDR_W | Static unit address pins |
| cmd_line | input | 1 | Serial command line, sampled at crossing rate |
| trig_line | input | 1 | Shared trigger/reset line, sampled at crossing rate |
| col_a | input | 1 | Serial data from column A |
| col_b | input | 1 | Serial data from column B |
| rd_clk | output | 1 | Readout clock to the chips |
| ser_out | output | 1 | Interleaved output stream |
| trig_out | output | 1 | Decoded trigger, one crossing period long |
| chip_rst | output | 1 | Decoded chip reset |
| cmd_stb | output | 1 | One-clock strobe for an accepted command |
| cmd_code | output | CMD_W | Code of the last accepted command |

## Verification
The hardest situations to reach are the ones where the crossing-rate decoders and the fast interleaver are active together. One example is a trigger or reset pulse that lands during an addressed frame, while column data changes on every clock. The stimulus schedules the trigger-line pattern and the command frames as per-crossing-sample queues that run in parallel. Column bits are randomised on every clock edge, so any slip in slot timing shows up as a wrong bit. The whole schedule is run once in each readout mode, with a reset between the two runs.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int PH_W = 2;

    // slot strobes for one clock edge
    typedef struct packed {
        logic bc;     // crossing-rate sample point
        logic first;  // readout cycle start (column A slot)
        logic second; // column B slot
        logic rd_hi;  // readout clock level after this edge
    } slot_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    function automatic logic addr_match(input logic [15:0] frame_addr,
                                        input logic [15:0] own_addr,
                                        input int          width);
        logic [15:0] mask;
        mask = (16'd1 << width) - 16'd1;
        return ((frame_addr & mask) == (own_addr & mask)) ||
               ((frame_addr & mask) == mask);
    endfunction

endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fast_mode,
    output slot_t slot,
    output logic  rd_clk
);
    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= ph + 1'b1;
    end

    always_comb begin
        slot.bc = (ph == '0);
        if (fast_mode) begin
            slot.first  = ~ph[0];
            slot.second =  ph[0];
            slot.rd_hi  = ~ph[0];
        end else begin
            slot.first  = (ph == 2'd0);
            slot.second = (ph == 2'd2);
            slot.rd_hi  = ~ph[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_clk <= 1'b0;
        else     rd_clk <= slot.rd_hi;
    end

    // R2
    fast_rd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (fast_mode && rd_clk) |=> !rd_clk);
endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
    import ilv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    input  logic  col_a,
    input  logic  col_b,
    output logic  ser_out
);
    logic b_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out <= 1'b0;
            b_hold  <= 1'b0;
        end else if (slot.first) begin
            ser_out <= col_a;
            b_hold  <= col_b;
        end else if (slot.second) begin
            ser_out <= b_hold;
        end
    end

    // R4
    ser_only_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !(slot.first || slot.second) |=> $stable(ser_out));
endmodule

// File: rtl/ilv_line_decoder.sv
module ilv_line_decoder
    import ilv_pkg::*;
#(
    parameter int RUN_W = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    input  logic  trig_line,
    output logic  trig_out,
    output logic  chip_rst
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= '0;
            trig_out <= 1'b0;
            chip_rst <= 1'b0;
        end else if (slot.bc) begin
            if (trig_line) begin
                run      <= (run == RUN_MAX) ? run : run + 1'b1;
                trig_out <= 1'b0;
                chip_rst <= (run >= RUN_W'(2));
            end else begin
                run      <= '0;
                trig_out <= (run == RUN_W'(1));
                chip_rst <= 1'b0;
            end
        end
    end

    // R8
    trig_rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trig_out, chip_rst}));

    // R6
    trig_bc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        !slot.bc |=> $stable(trig_out));
endmodule

// File: rtl/ilv_cmd_rx.sv
module ilv_cmd_rx
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot,
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic              cmd_line,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code
);
    localparam int FRAME_BITS = ADDR_W + CMD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    rx_state_e             state;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] frame_w;
    logic [ADDR_W-1:0]     f_addr;
    logic                  hit;

    always_comb begin
        frame_w = {shreg[FRAME_BITS-2:0], cmd_line};
        f_addr  = frame_w[FRAME_BITS-1 -: ADDR_W];
        hit     = addr_match(16'(f_addr), 16'(unit_addr), ADDR_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (slot.bc) begin
                case (state)
                    RX_IDLE: begin
                        if (cmd_line) begin
                            state <= RX_SHIFT;
                            cnt   <= '0;
                        end
                    end
                    default: begin
                        shreg <= frame_w;
                        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                            state <= RX_IDLE;
                            if (hit) begin
                                cmd_stb  <= 1'b1;
                                cmd_code <= frame_w[CMD_W-1:0];
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R9
    cmd_stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);
endmodule

// File: rtl/dual_col_interleaver.sv
module dual_col_interleaver
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CMD_W  = 4,
    parameter int RUN_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_mode,
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic              cmd_line,
    input  logic              trig_line,
    input  logic              col_a,
    input  logic              col_b,
    output logic              rd_clk,
    output logic              ser_out,
    output logic              trig_out,
    output logic              chip_rst,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code
);
    slot_t slot;

    ilv_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .fast_mode (fast_mode),
        .slot      (slot),
        .rd_clk    (rd_clk)
    );

    ilv_serializer u_ser (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .col_a   (col_a),
        .col_b   (col_b),
        .ser_out (ser_out)
    );

    ilv_line_decoder #(.RUN_W(RUN_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .trig_line (trig_line),
        .trig_out  (trig_out),
        .chip_rst  (chip_rst)
    );

    ilv_cmd_rx #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .unit_addr (unit_addr),
        .cmd_line  (cmd_line),
        .cmd_stb   (cmd_stb),
        .cmd_code  (cmd_code)
    );
endmodule

// File: tb/tb_dual_col_interleaver.sv
module tb_dual_col_interleaver;
    localparam int ADDR_W = 5;
    localparam int CMD_W  = 4;
    localparam logic [ADDR_W-1:0] OWN = 5'h0B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fast_mode = 1'b0;
    logic [ADDR_W-1:0] unit_addr = OWN;
    logic cmd_line = 1'b0, trig_line = 1'b0, col_a = 1'b0, col_b = 1'b0;
    logic rd_clk, ser_out, trig_out, chip_rst, cmd_stb;
    logic [CMD_W-1:0] cmd_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_col_interleaver #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) dut (
        .clk(clk), .rst(rst), .fast_mode(fast_mode), .unit_addr(unit_addr),
        .cmd_line(cmd_line), .trig_line(trig_line), .col_a(col_a), .col_b(col_b),
        .rd_clk(rd_clk), .ser_out(ser_out), .trig_out(trig_out),
        .chip_rst(chip_rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    bit line_q[$];
    bit cmd_q[$];
    int exp_cmd[$];
    int got_cmd[$];
    bit ref_a[$], ref_b[$], got_a[$], got_b[$];

    task automatic add_frame(input int addr, input int code);
        cmd_q.push_back(1'b1);
        for (int i = ADDR_W - 1; i >= 0; i--) cmd_q.push_back(addr[i]);
        for (int i = CMD_W - 1; i >= 0; i--) cmd_q.push_back(code[i]);
        cmd_q.push_back(1'b0);
        cmd_q.push_back(1'b0);
        if (addr == int'(OWN) || addr == (1 << ADDR_W) - 1) exp_cmd.push_back(code);
    endtask

    task automatic add_pulse(input int len, input int gap);
        for (int i = 0; i < len; i++) line_q.push_back(1'b1);
        for (int i = 0; i < gap; i++) line_q.push_back(1'b0);
    endtask

    task automatic run_mode(input bit fm, input string mname);
        bit  sb, exp_ser, exp_trig, exp_rst;
        int  run;
        rst = 1'b1; fast_mode = fm;
        repeat (3) @(negedge clk);
        // R1: outputs after reset edges
        chk({"R1 ser_out ", mname}, ser_out, 0);
        chk({"R1 rd_clk ", mname}, rd_clk, 0);
        chk({"R1 trig_out ", mname}, trig_out, 0);
        chk({"R1 chip_rst ", mname}, chip_rst, 0);
        chk({"R1 cmd_stb ", mname}, cmd_stb, 0);
        line_q.delete(); cmd_q.delete(); exp_cmd.delete(); got_cmd.delete();
        ref_a.delete(); ref_b.delete(); got_a.delete(); got_b.delete();
        line_q.push_back(1'b0);
        add_pulse(1, 2);  // R6 trigger
        add_pulse(2, 2);  // R7 ignored
        add_pulse(3, 2);  // R8 reset
        add_pulse(5, 1);  // R8 long reset
        add_pulse(1, 1);  // R6 back-to-back triggers
        add_pulse(1, 3);
        add_frame(int'(OWN), 3);   // R9
        add_frame(5'h0C, 7);       // R10 mismatch
        add_frame(5'h1F, 9);       // R10 broadcast
        add_frame(int'(OWN), 14);  // R9
        sb = 0; exp_ser = 0; exp_trig = 0; exp_rst = 0; run = 0;
        trig_line = line_q.size() ? line_q.pop_front() : 1'b0;
        cmd_line  = cmd_q.size() ? cmd_q.pop_front() : 1'b0;
        col_a = $urandom % 2; col_b = $urandom % 2;
        rst = 1'b0;
        for (int n = 0; n < 400; n++) begin
            bit first, second, exp_rd;
            int ph;
            @(negedge clk);
            ph = n % 4;
            first  = fm ? (ph % 2 == 0) : (ph == 0);
            second = fm ? (ph % 2 == 1) : (ph == 2);
            exp_rd = fm ? (ph % 2 == 0) : (ph < 2);
            if (first) begin
                exp_ser = col_a; sb = col_b;
                ref_a.push_back(col_a); ref_b.push_back(col_b);
                got_a.push_back(ser_out);
            end
            if (second) begin
                exp_ser = sb;
                got_b.push_back(ser_out);
            end
            if (ph == 0) begin
                if (trig_line) begin
                    run++; exp_trig = 0; exp_rst = (run >= 3);
                end else begin
                    exp_trig = (run == 1); exp_rst = 0; run = 0;
                end
            end
            chk({"R2 rd_clk ", mname}, rd_clk, exp_rd);
            chk(fm ? "R3 ser_out fast" : "R4 ser_out slow", ser_out, exp_ser);
            chk({"R6 R7 trig_out ", mname}, trig_out, exp_trig);
            chk({"R8 chip_rst ", mname}, chip_rst, exp_rst);
            if (cmd_stb) got_cmd.push_back(int'(cmd_code));
            col_a = $urandom % 2; col_b = $urandom % 2;
            if ((n + 1) % 4 == 0) begin
                trig_line = line_q.size() ? line_q.pop_front() : 1'b0;
                cmd_line  = cmd_q.size() ? cmd_q.pop_front() : 1'b0;
            end
        end
        // R5 de-interleaved streams
        chk({"R5 col A length ", mname}, got_a.size(), ref_a.size());
        chk({"R5 col B length ", mname}, got_b.size(), ref_b.size());
        for (int i = 0; i < got_a.size() && i < ref_a.size(); i++)
            chk({"R5 col A bit ", mname}, got_a[i], ref_a[i]);
        for (int i = 0; i < got_b.size() && i < ref_b.size(); i++)
            chk({"R5 col B bit ", mname}, got_b[i], ref_b[i]);
        // R9 R10 accepted command list
        chk({"R10 command count ", mname}, got_cmd.size(), exp_cmd.size());
        for (int i = 0; i < got_cmd.size() && i < exp_cmd.size(); i++)
            chk({"R9 command code ", mname}, got_cmd[i], exp_cmd[i]);
    endtask

    initial begin
        run_mode(1'b1, "fast");
        run_mode(1'b0, "slow");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule